// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block splits every instruction cycle of a small processor into four consecutive phases, Q1 to Q4, each one oscillator clock long. All logic runs on the oscillator clock. The phases are clock-enable strobes, not derived clocks. From the phase position the block produces the action strobes a datapath needs. The program counter advances in Q1. Operand data is read in Q2. In Q4 the instruction register loads and the destination write takes place. A one-clock pulse marks the start of each instruction cycle. A quarter-rate clock-out signal has one period per instruction cycle.

A hold input stalls the sequencer. While hold is high, the phase stays where it is and every action strobe is held low. When hold drops, the current phase completes on that clock, and the sequence moves on from there. Reset is synchronous. After reset is released, the first clock shows Q1.

Each action strobe goes high on the last clock of its phase, which is the clock on which the phase advances. Each strobe therefore fires exactly once per instruction cycle, however long the cycle is stretched by hold.

Top module: `qseq_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, after that edge `phase_o` is 0, every action strobe is 0 and `clk_out_o` is 0.
- R2: On the first clock edge with `rst_i` low after reset, the sequencer becomes active and `phase_o` shows Q1 (value 4'b0001).
- R3: Once active, `phase_o` is one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. On every clock edge where `hold_i` is low, it moves one phase on: Q1→Q2→Q3→Q4→Q1.
- R4: `pc_adv_o` equals Q1 AND NOT `hold_i`.
- R5: `opnd_rd_o` equals Q2 AND NOT `hold_i`.
- R6: `ir_load_o` and `dest_wr_o` each equal Q4 AND NOT `hold_i`.
- R7: `cyc_start_o` equals Q1 AND NOT `hold_i`. It is high for exactly one clock per instruction cycle.
- R8: While `hold_i` is high, `phase_o` keeps its value across clock edges and all five action strobes are 0.
- R9: `clk_out_o` is 0 in Q1 and Q2 and 1 in Q3 and Q4. It therefore keeps its level during hold, and without hold it has a period of four clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Stall: freezes the phase and masks the action strobes |
| phase_o | output | 4 | One-hot phase enables, bit 0 = Q1 … bit 3 = Q4 |
| pc_adv_o | output | 1 | Program counter advance strobe (Q1) |
| opnd_rd_o | output | 1 | Operand read strobe (Q2) |
| ir_load_o | output | 1 | Instruction register load strobe (Q4) |
| dest_wr_o | output | 1 | Destination write strobe (Q4) |
| cyc_start_o | output | 1 | Instruction cycle start pulse (Q1) |
| clk_out_o | output | 1 | Quarter-rate clock-out |

## Verification
A corrupted phase register appears on `phase_o` on the very next clock. It shows either as a bit pattern that is not one-hot or as a step that skips or repeats a phase. A wrong action strobe then follows in the same clock, since the strobes are decoded directly from that state. A hold that fails to freeze the phase, or fails to mask the strobes, also shows within one clock. The reference model in the bench tracks the phase independently and compares every output on every clock. Any such error is therefore reported no later than the clock after it appears.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int unsigned N_PHASES = 4;
  localparam int unsigned PH_W     = $clog2(N_PHASES);

  typedef enum logic [PH_W-1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qphase_e;
endpackage

// File: rtl/qseq_phase_ctr.sv
module qseq_phase_ctr
  import qseq_pkg::*;
#(
  parameter int unsigned NPH = N_PHASES,
  localparam int unsigned PW = $clog2(NPH)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hold_i,
  output logic          run_o,
  output logic [PW-1:0] ph_o,
  output logic [NPH-1:0] onehot_o
);
  localparam logic [PW-1:0] LAST = PW'(NPH - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_o <= 1'b0;
      ph_o  <= '0;
    end else if (!run_o) begin
      run_o <= 1'b1;
    end else if (!hold_i) begin
      ph_o <= (ph_o == LAST) ? '0 : ph_o + 1'b1;
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_dec
    assign onehot_o[g] = run_o && (ph_o == PW'(g));
  end

  AST_ONEHOT_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    run_o |-> $countones(onehot_o) == 1); // R3
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_o && hold_i) |=> $stable(onehot_o)); // R8
  AST_START_Q1: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(run_o) |-> onehot_o[0]); // R2
endmodule

// File: rtl/qseq_strobe_dec.sv
module qseq_strobe_dec
  import qseq_pkg::*;
#(
  parameter int unsigned NPH = N_PHASES
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           hold_i,
  input  logic [NPH-1:0] phase_i,
  output logic           pc_adv_o,
  output logic           opnd_rd_o,
  output logic           ir_load_o,
  output logic           dest_wr_o,
  output logic           cyc_start_o
);
  logic go;
  assign go = !hold_i;

  always_comb begin
    pc_adv_o    = go && phase_i[PH_Q1];
    cyc_start_o = go && phase_i[PH_Q1];
    opnd_rd_o   = go && phase_i[PH_Q2];
    ir_load_o   = go && phase_i[PH_Q4];
    dest_wr_o   = go && phase_i[PH_Q4];
  end

  AST_NO_STROBE_IN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_i |-> !(pc_adv_o || opnd_rd_o || ir_load_o || dest_wr_o || cyc_start_o)); // R8
  AST_WRITE_IN_Q4: assert property (@(posedge clk_i) disable iff (rst_i)
    dest_wr_o |=> phase_i[PH_Q1]); // R6
  AST_START_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
    cyc_start_o |=> !cyc_start_o); // R7
endmodule

// File: rtl/qseq_clkout.sv
module qseq_clkout
  import qseq_pkg::*;
#(
  parameter int unsigned NPH = N_PHASES
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           hold_i,
  input  logic [NPH-1:0] phase_i,
  output logic           clk_out_o
);
  assign clk_out_o = phase_i[PH_Q3] || phase_i[PH_Q4];

  AST_CLKO_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones(phase_i) == 1 && hold_i) |=> $stable(clk_out_o)); // R9
  AST_CLKO_RISE_Q3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(clk_out_o) |-> phase_i[PH_Q3]); // R9
endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       hold_i,
  output logic [3:0] phase_o,
  output logic       pc_adv_o,
  output logic       opnd_rd_o,
  output logic       ir_load_o,
  output logic       dest_wr_o,
  output logic       cyc_start_o,
  output logic       clk_out_o
);
  logic            run;
  logic [PH_W-1:0] ph;

  qseq_phase_ctr #(.NPH(N_PHASES)) i_ctr (
    .clk_i(clk_i), .rst_i(rst_i), .hold_i(hold_i),
    .run_o(run), .ph_o(ph), .onehot_o(phase_o)
  );

  qseq_strobe_dec #(.NPH(N_PHASES)) i_dec (
    .clk_i(clk_i), .rst_i(rst_i), .hold_i(hold_i), .phase_i(phase_o),
    .pc_adv_o(pc_adv_o), .opnd_rd_o(opnd_rd_o), .ir_load_o(ir_load_o),
    .dest_wr_o(dest_wr_o), .cyc_start_o(cyc_start_o)
  );

  qseq_clkout #(.NPH(N_PHASES)) i_clko (
    .clk_i(clk_i), .rst_i(rst_i), .hold_i(hold_i), .phase_i(phase_o),
    .clk_out_o(clk_out_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (phase_o == 4'b0 && !clk_out_o)); // R1
  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
    (run && !hold_i) |=> ph == ((PH_W'($past(ph)) + 1'b1) & PH_W'(N_PHASES - 1))); // R3
endmodule

// File: tb/test_qseq_top.sv
`timescale 1ns/1ps
module test_qseq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic [3:0] phase;
  logic       pc_adv, opnd_rd, ir_load, dest_wr, cyc_start, clk_out;

  int n_tests = 0;
  int n_fail  = 0;
  int m_run   = 0;
  int m_ph    = 0;
  int starts_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qseq_top i_qseq_top (
    .clk_i(clk), .rst_i(rst), .hold_i(hold), .phase_o(phase),
    .pc_adv_o(pc_adv), .opnd_rd_o(opnd_rd), .ir_load_o(ir_load),
    .dest_wr_o(dest_wr), .cyc_start_o(cyc_start), .clk_out_o(clk_out)
  );

  // behavioural reference: advanced after each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_run <= 0; m_ph <= 0;
    end else if (m_run == 0) begin
      m_run <= 1;
    end else if (!hold) begin
      m_ph <= (m_ph + 1) % 4;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_ph;
    bit g;
    exp_ph = m_run ? (1 << m_ph) : 0;
    g = !hold && m_run != 0;
    check(rst ? "R1 phase" : "R3 phase", phase, exp_ph);
    check(hold ? "R8 pc_adv" : "R4 pc_adv", pc_adv, g && m_ph == 0);
    check("R5 opnd_rd", opnd_rd, g && m_ph == 1);
    check("R6 ir_load", ir_load, g && m_ph == 3);
    check("R6 dest_wr", dest_wr, g && m_ph == 3);
    check("R7 cyc_start", cyc_start, g && m_ph == 0);
    check("R9 clk_out", clk_out, m_run != 0 && m_ph >= 2);
  endtask

  // one step: drive on falling edge, compare shortly after
  task automatic step(input bit r, input bit h);
    @(negedge clk);
    rst = r; hold = h;
    #0.5;
    compare_all();
    if (cyc_start) starts_seen++;
  endtask

  initial begin
    repeat (3) step(1, 0);
    check("R1 reset phase", phase, 0);
    step(0, 0);
    @(posedge clk); #0.5;
    check("R2 first phase", phase, 1);
    // free run: count cycle starts over 40 clocks
    starts_seen = 0;
    repeat (40) step(0, 0);
    check("R7 starts per 40 clocks", starts_seen, 10);
    // hold in each phase for several clocks
    for (int p = 0; p < 4; p++) begin
      repeat (3) step(0, 1);
      step(0, 0);
    end
    // mixed hold patterns
    for (int i = 0; i < 400; i++) step(0, ($urandom % 3) == 0);
    // reset mid-run, hold asserted immediately after release
    repeat (2) step(1, 1);
    step(0, 1);
    repeat (3) step(0, 1);
    @(posedge clk); #0.5;
    check("R2 Q1 under hold", phase, 1);
    check("R8 held strobe", pc_adv, 0);
    repeat (20) step(0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule